// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a synthesizable behavioural model of a flow-through synchronous burst SRAM that holds its storage on chip. Every synchronous control (address, both address strobes, the three chip enables, the advance input, the global and per-lane write enables and the write data) is captured on the rising clock edge. A new external address is taken either by the processor strobe, which always starts a read, or by the controller strobe, which may start a write at once. After that, a two-bit burst counter steps through four neighbouring words under the advance input.

Reads are flow-through. The word at the registered address reaches the data output in the cycle that follows the edge, with no extra pipeline register. The output enable is asynchronous and only gates the output drivers. The word is split into byte lanes, and each lane carries one parity bit. A global write stores every lane. A byte write stores only the lanes whose enables are low.

Top module: `sync_burst_sram`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the device becomes deselected. In the cycle after reset, `q` is all zero and `q_drive` is low.
- R2: When `adsp_n` and `ce_n` are both low at an edge, `addr` is loaded and a read is performed. No lane is written on that edge, whatever `gw_n`, `bwe_n`, `bw_n` and `adsc_n` say. With `oe_n` low, the stored word at `addr` is on `q` during the next cycle.
- R3: When `ce_n` is high, a low `adsp_n` is ignored. With `adsc_n` high, the burst in progress continues as if no strobe had been given.
- R4: When `adsc_n` is low and the processor strobe is not taken, `addr` is loaded and the write decode applies on that same edge at `addr`.
- R5: The chip enables are sampled only on edges that load an address. The device is selected only if `ce_n` is low, `ce2` is high and `ce2_n` is low. A deselected device writes nothing, and `q` reads zero with `q_drive` low. Changing the enables on non-load edges has no effect.
- R6: On a non-load edge with the device selected and `adv_n` low, the two low address bits step by one and wrap from 3 to 0. The upper bits stay fixed.
- R7: On a non-load edge with `adv_n` high, the address holds (wait state). A write in that cycle goes to the held address.
- R8: When `gw_n` is low on a write-permitted edge, all lanes are written, whatever `bwe_n` and `bw_n` say.
- R9: When `gw_n` is high and `bwe_n` is low, lane i is written only if `bw_n[i]` is low. Lane i is the 9-bit field `din[9*i +: 9]`: eight data bits, with the lane's parity bit as the field's top bit.
- R10: When `gw_n` and `bwe_n` are both high, the edge writes nothing.
- R11: `oe_n` acts without a clock. While it is high, `q` is all zero and `q_drive` is low.
- R12: In the cycle after an edge that wrote any lane, `q_drive` is low. `q` still shows the stored word at the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | External word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce2_n | input | 1 | Secondary chip enable, active low |
| gw_n | input | 1 | Global (full word) write, active low |
| bwe_n | input | 1 | Byte-write permit, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*9 | Write data, nine bits per lane |
| q | output | LANES*9 | Flow-through read data, zero when not driven |
| q_drive | output | 1 | High when the output drivers would be on |

## Verification
The bench builds the block with the default parameters: a 6-bit address, four lanes and eight data bits per lane. This gives 64 words of 36 bits. With so few words, random traffic keeps revisiting addresses already written. It also crosses the burst wrap from 3 to 0 inside every aligned group of four. Four lanes make every lane pattern reachable, so the global-write override and lane-by-lane masking, parity bits included, are all exercised.

// File: rtl/sbs_pkg.sv
// Shared definitions for the synchronous burst SRAM model.
// Assumes the burst counter always spans two address bits.
package sbs_pkg;

    parameter int unsigned SBS_BURST_BITS = 2;

    // Kind of write selected for one clock edge.
    typedef enum logic [1:0] {
        WK_NONE  = 2'd0,
        WK_BYTES = 2'd1,
        WK_FULL  = 2'd2
    } wr_kind_e;

endpackage

// File: rtl/sbs_ctrl.sv
// Strobe arbitration and chip-enable qualification.
// The processor strobe wins when the primary enable is low. The controller
// strobe loads only when the processor strobe is not taken. The chip
// enables are sampled only on load edges, and the result is kept in sel_q.
// Assumes a synchronous active-low reset.
module sbs_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic adsp_n,
    input  logic adsc_n,
    input  logic ce_n,
    input  logic ce2,
    input  logic ce2_n,
    output logic adsp_take,
    output logic adsc_take,
    output logic load,
    output logic enable_now,
    output logic sel_q
);

    // Decide which strobe, if any, loads an address this cycle.
    always_comb begin
        adsp_take  = !adsp_n && !ce_n;
        adsc_take  = !adsc_n && !adsp_take;
        load       = adsp_take || adsc_take;
        enable_now = !ce_n && ce2 && !ce2_n;
    end

    // Capture the selection state on load edges only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (load) begin
            sel_q <= enable_now;
        end
    end

endmodule

// File: rtl/sbs_burst_addr.sv
// Burst address register.
// On a load it takes the external address. Otherwise, while selected, it
// steps the low burst bits with a wrap (advance low) or holds (advance
// high). eff_addr is the address used by any write on this edge.
module sbs_burst_addr
    import sbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              sel_q,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int unsigned BB = SBS_BURST_BITS;
    localparam int unsigned UW = ADDR_W - BB;

    logic [BB-1:0] stepped;

    // Next burst position, wrapping within the aligned group.
    always_comb begin
        stepped = cur_addr[BB-1:0] + BB'(1);
    end

    // Select the address this edge acts on.
    always_comb begin
        if (load) begin
            eff_addr = addr;
        end else if (!adv_n) begin
            eff_addr = {cur_addr[ADDR_W-1:BB], stepped};
        end else begin
            eff_addr = cur_addr;
        end
    end

    // Update the registered address on load or while a burst is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else if (load || sel_q) begin
            cur_addr <= eff_addr;
        end
    end

    // Guard against an address too narrow to hold a burst.
    if (UW < 1) begin : g_bad_width
        $error("ADDR_W must exceed the burst width");
    end

endmodule

// File: rtl/sbs_write_decode.sv
// Write decode. A global write selects every lane. A byte write selects
// the lanes whose enable is low. With neither, nothing is written.
// allow is low on read-only or deselected edges.
module sbs_write_decode
    import sbs_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic             allow,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_we
);

    wr_kind_e kind;

    // Classify the write request; the global write has priority.
    always_comb begin
        if (!allow)       kind = WK_NONE;
        else if (!gw_n)   kind = WK_FULL;
        else if (!bwe_n)  kind = WK_BYTES;
        else              kind = WK_NONE;
    end

    // Expand the request into per-lane strobes.
    always_comb begin
        case (kind)
            WK_FULL:  lane_we = '1;
            WK_BYTES: lane_we = ~bw_n;
            default:  lane_we = '0;
        endcase
    end

endmodule

// File: rtl/sbs_array.sv
// Lane-split storage with one write port per lane and a shared
// combinational read. Each lane holds its data bits and its parity bit.
// Contents are not reset.
module sbs_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Store this lane when its strobe is set.
        always_ff @(posedge clk) begin
            if (lane_we[i]) begin
                mem[wr_addr] <= wr_data[i*LANE_W +: LANE_W];
            end
        end

        // Flow-through read of this lane.
        assign rd_data[i*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/sync_burst_sram.sv
// Top level of the flow-through synchronous burst SRAM model.
// Combines the strobe control, the burst address register, the write
// decode and the storage. Read data is combinational from the registered
// address. oe_n gates the output without a clock, and the drivers stay off
// in the cycle after a write. Assumes a synchronous active-low reset.
module sync_burst_sram #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          adsp_n,
    input  logic                          adsc_n,
    input  logic                          adv_n,
    input  logic                          ce_n,
    input  logic                          ce2,
    input  logic                          ce2_n,
    input  logic                          gw_n,
    input  logic                          bwe_n,
    input  logic [LANES-1:0]              bw_n,
    input  logic                          oe_n,
    input  logic [LANES*(DATA_W+1)-1:0]   din,
    output logic [LANES*(DATA_W+1)-1:0]   q,
    output logic                          q_drive
);

    localparam int unsigned LANE_W = DATA_W + 1;
    localparam int unsigned WORD_W = LANES * LANE_W;

    logic              adsp_take;
    logic              adsc_take;
    logic              load;
    logic              enable_now;
    logic              sel_q;
    logic              allow;
    logic              wr_q;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] cur_addr;
    logic [WORD_W-1:0] rd_data;

    sbs_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .adsp_n     (adsp_n),
        .adsc_n     (adsc_n),
        .ce_n       (ce_n),
        .ce2        (ce2),
        .ce2_n      (ce2_n),
        .adsp_take  (adsp_take),
        .adsc_take  (adsc_take),
        .load       (load),
        .enable_now (enable_now),
        .sel_q      (sel_q)
    );

    sbs_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .sel_q    (sel_q),
        .adv_n    (adv_n),
        .addr     (addr),
        .eff_addr (eff_addr),
        .cur_addr (cur_addr)
    );

    // Writes are permitted on controller loads of a selected device and on
    // burst edges of a selected device; never on processor-strobe loads.
    always_comb begin
        if (adsc_take)  allow = enable_now;
        else if (load)  allow = 1'b0;
        else            allow = sel_q;
    end

    sbs_write_decode #(.LANES(LANES)) u_dec (
        .allow   (allow),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .lane_we (lane_we)
    );

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .lane_we (lane_we),
        .wr_addr (eff_addr),
        .wr_data (din),
        .rd_addr (cur_addr),
        .rd_data (rd_data)
    );

    // Remember whether the last edge wrote, to keep the drivers off.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b0;
        else        wr_q <= |lane_we;
    end

    // Asynchronous output gating.
    always_comb begin
        q       = (sel_q && !oe_n) ? rd_data : '0;
        q_drive = sel_q && !oe_n && !wr_q;
    end

endmodule

// File: rtl/sbs_checker.sv
// Property checks for sync_burst_sram, attached through bind.
module sbs_checker #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adsp_n,
    input logic              adsc_n,
    input logic              ce_n,
    input logic              adv_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic              q_drive,
    input logic              load,
    input logic              sel_q,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [LANES-1:0]  lane_we
);

    assert_reset_deselect_R1: assert property (@(posedge clk)
        !rst_n |=> (!sel_q && !q_drive));

    assert_adsp_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce_n) |-> (lane_we == '0));

    assert_adsp_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce_n) |=> (cur_addr == $past(addr)));

    assert_adsp_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && adsc_n) |-> !load);

    assert_burst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q && !load && !adv_n) |=>
        ((cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1)) &&
         (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]))));

    assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q && !load && adv_n) |=> $stable(cur_addr));

    assert_oe_gates_R11: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !q_drive);

    assert_quiet_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_we) |=> !q_drive);

endmodule

bind sync_burst_sram sbs_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .adsp_n   (adsp_n),
    .adsc_n   (adsc_n),
    .ce_n     (ce_n),
    .adv_n    (adv_n),
    .oe_n     (oe_n),
    .addr     (addr),
    .q_drive  (q_drive),
    .load     (load),
    .sel_q    (sel_q),
    .cur_addr (cur_addr),
    .lane_we  (lane_we)
);

// File: tb/sync_burst_sram_bench.sv
`timescale 1ns/1ps
module sync_burst_sram_bench;

    localparam int AW    = 6;
    localparam int LN    = 4;
    localparam int DW    = 8;
    localparam int LW    = DW + 1;
    localparam int NW    = LN * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic          ce_n = 1'b0, ce2 = 1'b1, ce2_n = 1'b0;
    logic          gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
    logic [LN-1:0] bw_n = '1;
    logic [NW-1:0] din = '0;
    logic [NW-1:0] q;
    logic          q_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NW-1:0] ref_mem [DEPTH];
    bit            m_sel = 0, m_wr = 0;
    logic [AW-1:0] m_addr = '0;

    always #2.5 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .LANES(LN), .DATA_W(DW)) u_sync_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .din(din), .q(q), .q_drive(q_drive)
    );

    task automatic check_eq(string tag, logic [NW-1:0] act, logic [NW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance the reference by one edge using the currently driven inputs.
    task automatic model_edge();
        bit adsp_t, adsc_t, ld, en, permit;
        logic [AW-1:0] eff;
        logic [LN-1:0] mask;
        if (!rst_n) begin
            m_sel = 0; m_wr = 0; m_addr = '0;
            return;
        end
        adsp_t = !adsp_n && !ce_n;
        adsc_t = !adsc_n && !adsp_t;
        ld     = adsp_t || adsc_t;
        en     = !ce_n && ce2 && !ce2_n;
        permit = adsp_t ? 1'b0 : (adsc_t ? en : m_sel);
        if (ld)          eff = addr;
        else if (!adv_n) eff = {m_addr[AW-1:2], 2'(m_addr[1:0] + 2'd1)};
        else             eff = m_addr;
        mask = !permit ? '0 : (!gw_n ? '1 : (!bwe_n ? ~bw_n : '0));
        for (int i = 0; i < LN; i++)
            if (mask[i]) ref_mem[eff][i*LW +: LW] = din[i*LW +: LW];
        m_wr = |mask;
        if (ld || m_sel) m_addr = eff;
        if (ld) m_sel = en;
    endtask

    task automatic check_outputs(string tag);
        logic [NW-1:0] exp_q;
        exp_q = (m_sel && !oe_n) ? ref_mem[m_addr] : '0;
        check_eq(tag, q, exp_q);
        check_eq({tag, " drive"}, NW'(q_drive), NW'(m_sel && !oe_n && !m_wr));
    endtask

    // One clock: edge, model update, check at the falling edge.
    task automatic tick(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic idle();
        adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = '1;
        ce_n = 0; ce2 = 1; ce2_n = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [NW-1:0] saved, newd, exp;
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) tick("R1");
        rst_n = 1;
        tick("R1");
        check_eq("R1 q zero", q, '0);

        // R8/R4: preload every word with controller-strobe global writes
        for (int a = 0; a < DEPTH; a++) begin
            idle(); adsc_n = 0; addr = AW'(a); gw_n = 0; bwe_n = 1; bw_n = '1;
            din = NW'(64'h9E37_79B9_7F4A_7C15 * (a + 1));
            tick("R8");
        end
        idle(); tick("R12");

        // R2: processor strobe reads and ignores write enables
        saved = ref_mem[5];
        idle(); adsp_n = 0; adsc_n = 0; addr = 6'd5; gw_n = 0; bwe_n = 0; bw_n = '0; din = '1;
        tick("R2");
        check_eq("R2 read at 5", q, saved);

        // R6: burst from 6 wraps 7,4,5
        idle(); adsp_n = 0; addr = 6'd6; tick("R6");
        check_eq("R6 start", q, ref_mem[6]);
        idle(); adv_n = 0; tick("R6"); check_eq("R6 step1", q, ref_mem[7]);
        tick("R6"); check_eq("R6 wrap", q, ref_mem[4]);
        tick("R6"); check_eq("R6 step3", q, ref_mem[5]);

        // R7: wait states hold the address
        idle(); tick("R7"); check_eq("R7 hold", q, ref_mem[5]);

        // R3: processor strobe ignored with ce_n high
        idle(); adsp_n = 0; ce_n = 1; addr = 6'd40; adv_n = 0; tick("R3");
        check_eq("R3 continues", q, ref_mem[6]);

        // R4/R9: controller strobe byte write lanes 0 and 2
        saved = ref_mem[12];
        newd  = NW'(64'h0_5A5A_A5A5_3);
        idle(); adsc_n = 0; addr = 6'd12; bwe_n = 0; bw_n = 4'b1010; din = newd;
        tick("R9");
        exp = saved;
        exp[0 +: LW]  = newd[0 +: LW];
        exp[18 +: LW] = newd[18 +: LW];
        check_eq("R4 drive off after write", NW'(q_drive), '0);
        check_eq("R9 lanes 0,2", q, exp);

        // R10: no write when both write inputs high
        idle(); bw_n = '0; din = '0; tick("R10");
        check_eq("R10 unchanged", q, exp);
        check_eq("R12 drive back on", NW'(q_drive), NW'(1));

        // R5: deselecting load writes nothing and blanks the output
        saved = ref_mem[9];
        idle(); adsc_n = 0; ce2 = 0; addr = 6'd9; gw_n = 0; din = '1; tick("R5");
        check_eq("R5 deselected q", q, '0);
        idle(); adv_n = 0; gw_n = 0; tick("R5");
        idle(); adsp_n = 0; addr = 6'd9; tick("R5");
        check_eq("R5 no write", q, saved);
        idle(); adv_n = 0; ce2 = 0; ce2_n = 1; tick("R5");
        check_eq("R5 enables ignored mid-burst", q, ref_mem[10]);

        // R11: asynchronous output enable
        idle();
        oe_n = 1; #1;
        check_eq("R11 oe high q", q, '0);
        check_eq("R11 oe high drive", NW'(q_drive), '0);
        oe_n = 0; #1;
        check_eq("R11 oe low q", q, ref_mem[10]);
        @(negedge clk);

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            adsp_n = ($urandom % 100) >= 15;
            adsc_n = ($urandom % 100) >= 20;
            adv_n  = $urandom % 2;
            ce_n   = ($urandom % 100) >= 85;
            ce2    = ($urandom % 100) < 90;
            ce2_n  = ($urandom % 100) >= 90;
            gw_n   = ($urandom % 100) >= 10;
            bwe_n  = ($urandom % 100) >= 40;
            bw_n   = LN'($urandom);
            oe_n   = ($urandom % 100) >= 80;
            addr   = AW'($urandom);
            din    = NW'({$urandom, $urandom});
            tick("R2/R4/R6/R7/R9 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule